// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit sits in the memory stage of a 32-bit load/store core. For one single-register load or store, it takes the base register value, an offset and a few control fields. It returns the memory address, the value to write back into the base register with its enable, and a flag for an access that breaks natural alignment.

The offset is either a zero-extended immediate or a register value shifted left by 0 to 31 places. The offset is added to or subtracted from the base. Three indexing modes decide which of base and base±offset is sent to memory and which is written back.

For stores, the unit places the store data onto the byte lanes of the 32-bit bus and produces byte enables. For loads, it picks the addressed byte or halfword out of the returned bus word and zero- or sign-extends it to 32 bits. Little-endian byte order is used throughout.

A request is captured on a rising clock edge when `req_valid` is high. The address-side results are registered. The load value is formed combinationally from `ld_rdata` and the captured access.

Top module: `lsu_agu`

## Requirements
- R1: Index mode 0 (pre, no writeback) gives `eff_addr` = base ± offset with `wb_en` low, one cycle after the request.
- R2: Index mode 1 (pre with writeback) gives `eff_addr` = base ± offset, `wb_value` equal to that same address, and `wb_en` high.
- R3: Index mode 2 (post) gives `eff_addr` = unmodified base, `wb_value` = base ± offset, and `wb_en` high.
- R4: When `off_is_reg`=0 the offset is `imm_off` zero-extended. When it is 1 the offset is `reg_off` shifted left by `shift_amt` (0..31). With `off_up`=1 the offset is added, otherwise it is subtracted, modulo 2^32.
- R5: `misalign` is high when a word access (size 2 or 3) has a nonzero `eff_addr[1:0]`, or when a halfword access (size 1) has `eff_addr[0]`=1. A byte access (size 0) is never misaligned.
- R6: For stores, `st_lanes` is the low byte repeated four times (byte), the low halfword repeated twice (halfword), or `st_data` unchanged (word). `byte_en` is 1 shifted left by `eff_addr[1:0]` for a byte, 4'b0011 or 4'b1100 chosen by `eff_addr[1]` for a halfword, and 4'b1111 for a word. `byte_en` is 4'b0000 when `misalign` is high.
- R7: `ld_value` takes the byte at lane `eff_addr[1:0]` or the halfword at lane `eff_addr[1]` from `ld_rdata`. It sign-extends when `ld_signed`=1 and zero-extends otherwise. A word passes through unchanged.
- R8: After reset, `out_valid`, `wb_en` and `eff_addr` are zero.
- R9: A cycle with `req_valid` low gives `out_valid` and `wb_en` low on the next cycle, and `eff_addr` holds its previous value.
- R10: Index mode 3 behaves exactly as mode 0: address base ± offset, no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| base_val | input | 32 | Base register value |
| imm_off | input | 12 | Immediate offset (unsigned) |
| reg_off | input | 32 | Register offset value |
| shift_amt | input | 5 | Left shift applied to register offset |
| off_is_reg | input | 1 | 1 selects shifted register, 0 selects immediate |
| off_up | input | 1 | 1 adds offset, 0 subtracts it |
| idx_mode | input | 2 | 0 pre, 1 pre+writeback, 2 post, 3 as 0 |
| acc_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| ld_signed | input | 1 | Sign-extend loaded byte/halfword |
| st_data | input | 32 | Store data, right-aligned |
| ld_rdata | input | 32 | Load data returned from memory |
| out_valid | output | 1 | Registered results valid |
| eff_addr | output | 32 | Memory address |
| wb_value | output | 32 | Value for the base register |
| wb_en | output | 1 | Base register writeback enable |
| misalign | output | 1 | Access breaks natural alignment |
| byte_en | output | 4 | Store byte enables |
| st_lanes | output | 32 | Store data placed on bus lanes |
| ld_value | output | 32 | Aligned and extended load value |

## Verification
Address, writeback, misalignment, byte-enable and lane outputs appear one rising edge after the request is captured. The bench drives each request just after a falling edge and compares these outputs at the next falling edge, half a period after they change. The load value depends only on `ld_rdata` and the captured access, with no further register. The bench therefore presents fresh bus data after that comparison and reads `ld_value` 1 ns later, before the next rising edge. Hold behaviour after an idle cycle is checked at the same falling edge.

// File: rtl/agu_pkg.sv
// Shared encodings for the load/store address generation unit.
// Assumes a byte-addressed, little-endian memory.
package agu_pkg;
    typedef enum logic [1:0] {
        IDX_PRE    = 2'd0,
        IDX_PRE_WB = 2'd1,
        IDX_POST   = 2'd2,
        IDX_ALT    = 2'd3
    } idx_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } acc_size_e;
endpackage

// File: rtl/agu_offset.sv
// Offset former: selects a zero-extended immediate or a register value
// shifted left by 0..XLEN-1 places. Purely combinational, single cycle.
module agu_offset #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 12,
    localparam int SHW  = $clog2(XLEN)
) (
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  roff,
    input  logic [SHW-1:0]   shamt,
    input  logic             use_reg,
    output logic [XLEN-1:0]  offset
);
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] shifted;

    // Widen the immediate without sign.
    always_comb imm_ext = {{(XLEN-IMM_W){1'b0}}, imm};

    // Barrel shift of the register offset.
    always_comb shifted = roff << shamt;

    // Pick the offset source.
    always_comb offset = use_reg ? shifted : imm_ext;
endmodule

// File: rtl/agu_addr.sv
// Address and writeback former for the three indexing modes.
// Assumes the unused mode code behaves as plain preindex.
module agu_addr
    import agu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] offset,
    input  logic            up,
    input  logic [1:0]      mode,
    output logic [XLEN-1:0] addr,
    output logic [XLEN-1:0] wb_val,
    output logic            wb_req
);
    logic [XLEN-1:0] moved;
    idx_mode_e       m;

    // Decode the raw mode field.
    always_comb m = idx_mode_e'(mode);

    // Base moved by the offset, wrapping modulo 2^XLEN.
    always_comb moved = up ? (base + offset) : (base - offset);

    // Memory address and writeback request per mode.
    always_comb begin
        addr   = moved;
        wb_req = 1'b0;
        unique case (m)
            IDX_PRE_WB: wb_req = 1'b1;
            IDX_POST: begin
                addr   = base;
                wb_req = 1'b1;
            end
            default: wb_req = 1'b0;
        endcase
    end

    // Writeback always carries the moved base.
    always_comb wb_val = moved;
endmodule

// File: rtl/agu_store_align.sv
// Store-side alignment: misalignment detection, byte enables and
// replication of store data onto every bus lane. Little-endian.
module agu_store_align
    import agu_pkg::*;
#(
    parameter int XLEN    = 32,
    localparam int NBYTES = XLEN / 8,
    localparam int LSB_W  = $clog2(NBYTES)
) (
    input  logic [LSB_W-1:0]  lsb,
    input  logic [1:0]        size,
    input  logic [XLEN-1:0]   data,
    output logic              misalign,
    output logic [NBYTES-1:0] be,
    output logic [XLEN-1:0]   lanes
);
    localparam logic [NBYTES-1:0] ONE_B = {{(NBYTES-1){1'b0}}, 1'b1};
    localparam logic [NBYTES-1:0] TWO_B = {{(NBYTES-2){1'b0}}, 2'b11};

    acc_size_e       sz;
    logic [XLEN-1:0] rep_b;
    logic [XLEN-1:0] rep_h;

    // Decode the raw size field.
    always_comb sz = acc_size_e'(size);

    // Replicate the low byte and the low halfword across the bus.
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte_rep
        assign rep_b[8*i +: 8] = data[7:0];
    end
    for (genvar j = 0; j < NBYTES/2; j++) begin : g_half_rep
        assign rep_h[16*j +: 16] = data[15:0];
    end

    // Natural-alignment test for the requested size.
    always_comb begin
        unique case (sz)
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = lsb[0];
            default: misalign = |lsb;
        endcase
    end

    // Byte enables, suppressed for a misaligned access.
    always_comb begin
        unique case (sz)
            SZ_BYTE: be = ONE_B << lsb;
            SZ_HALF: be = TWO_B << {lsb[LSB_W-1:1], 1'b0};
            default: be = {NBYTES{1'b1}};
        endcase
        if (misalign) be = '0;
    end

    // Lane data per size.
    always_comb begin
        unique case (sz)
            SZ_BYTE: lanes = rep_b;
            SZ_HALF: lanes = rep_h;
            default: lanes = data;
        endcase
    end
endmodule

// File: rtl/agu_load_ext.sv
// Load-side alignment: picks the addressed byte or halfword from the
// returned bus word and extends it to XLEN bits. Little-endian.
module agu_load_ext
    import agu_pkg::*;
#(
    parameter int XLEN    = 32,
    localparam int NBYTES = XLEN / 8,
    localparam int LSB_W  = $clog2(NBYTES)
) (
    input  logic [LSB_W-1:0] lsb,
    input  logic [1:0]       size,
    input  logic             sext,
    input  logic [XLEN-1:0]  rdata,
    output logic [XLEN-1:0]  value
);
    acc_size_e       sz;
    logic [XLEN-1:0] b_shift;
    logic [XLEN-1:0] h_shift;
    logic [7:0]      b_pick;
    logic [15:0]     h_pick;

    // Decode the raw size field.
    always_comb sz = acc_size_e'(size);

    // Move the addressed lane down to bit 0.
    always_comb begin
        b_shift = rdata >> {lsb, 3'b000};
        h_shift = rdata >> {lsb[LSB_W-1:1], 4'b0000};
        b_pick  = b_shift[7:0];
        h_pick  = h_shift[15:0];
    end

    // Extend the picked item to full width.
    always_comb begin
        unique case (sz)
            SZ_BYTE: value = {{(XLEN-8){sext & b_pick[7]}}, b_pick};
            SZ_HALF: value = {{(XLEN-16){sext & h_pick[15]}}, h_pick};
            default: value = rdata;
        endcase
    end

    // A zero-extended byte load never carries upper bits (R7).
    always_comb begin
        if (sz == SZ_BYTE && !sext) begin
            assert_zext_byte_R7: assert (value[XLEN-1:8] == '0);
        end
    end
endmodule

// File: rtl/lsu_agu.sv
// Top of the load/store address generation unit. Forms the offset,
// address and writeback combinationally, registers them on an accepted
// request, and extends load data from the registered access.
// Assumes a synchronous active-low reset and little-endian memory.
module lsu_agu
    import agu_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 12,
    localparam int NBYTES = XLEN / 8,
    localparam int LSB_W  = $clog2(NBYTES),
    localparam int SHW    = $clog2(XLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [XLEN-1:0]   base_val,
    input  logic [IMM_W-1:0]  imm_off,
    input  logic [XLEN-1:0]   reg_off,
    input  logic [SHW-1:0]    shift_amt,
    input  logic              off_is_reg,
    input  logic              off_up,
    input  logic [1:0]        idx_mode,
    input  logic [1:0]        acc_size,
    input  logic              ld_signed,
    input  logic [XLEN-1:0]   st_data,
    input  logic [XLEN-1:0]   ld_rdata,
    output logic              out_valid,
    output logic [XLEN-1:0]   eff_addr,
    output logic [XLEN-1:0]   wb_value,
    output logic              wb_en,
    output logic              misalign,
    output logic [NBYTES-1:0] byte_en,
    output logic [XLEN-1:0]   st_lanes,
    output logic [XLEN-1:0]   ld_value
);
    logic [XLEN-1:0]   offset_c;
    logic [XLEN-1:0]   addr_c;
    logic [XLEN-1:0]   wbv_c;
    logic              wbreq_c;
    logic              mis_c;
    logic [NBYTES-1:0] be_c;
    logic [XLEN-1:0]   lanes_c;
    logic [1:0]        size_q;
    logic              sext_q;

    agu_offset #(.XLEN(XLEN), .IMM_W(IMM_W)) u_off (
        .imm     (imm_off),
        .roff    (reg_off),
        .shamt   (shift_amt),
        .use_reg (off_is_reg),
        .offset  (offset_c)
    );

    agu_addr #(.XLEN(XLEN)) u_addr (
        .base   (base_val),
        .offset (offset_c),
        .up     (off_up),
        .mode   (idx_mode),
        .addr   (addr_c),
        .wb_val (wbv_c),
        .wb_req (wbreq_c)
    );

    agu_store_align #(.XLEN(XLEN)) u_st (
        .lsb      (addr_c[LSB_W-1:0]),
        .size     (acc_size),
        .data     (st_data),
        .misalign (mis_c),
        .be       (be_c),
        .lanes    (lanes_c)
    );

    // Register stage: capture results of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wb_en     <= 1'b0;
            eff_addr  <= '0;
            wb_value  <= '0;
            misalign  <= 1'b0;
            byte_en   <= '0;
            st_lanes  <= '0;
            size_q    <= SZ_WORD;
            sext_q    <= 1'b0;
        end else begin
            out_valid <= req_valid;
            wb_en     <= req_valid & wbreq_c;
            if (req_valid) begin
                eff_addr <= addr_c;
                wb_value <= wbv_c;
                misalign <= mis_c;
                byte_en  <= be_c;
                st_lanes <= lanes_c;
                size_q   <= acc_size;
                sext_q   <= ld_signed;
            end
        end
    end

    agu_load_ext #(.XLEN(XLEN)) u_ld (
        .lsb   (eff_addr[LSB_W-1:0]),
        .size  (size_q),
        .sext  (sext_q),
        .rdata (ld_rdata),
        .value (ld_value)
    );

    // Plain preindex and the spare code never request writeback (R1, R10).
    assert_no_wb_pre_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) && ($past(idx_mode) == 2'd0 || $past(idx_mode) == 2'd3)
        |-> !wb_en);

    // Preindex with writeback returns the accessed address (R2).
    assert_wb_is_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) && $past(idx_mode) == 2'd1 |-> wb_en && wb_value == eff_addr);

    // Postindex accesses the untouched base (R3).
    assert_post_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) && $past(idx_mode) == 2'd2 |-> eff_addr == $past(base_val));

    // An aligned word really sits on a word boundary (R5).
    assert_word_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && size_q[1] && !misalign |-> eff_addr[LSB_W-1:0] == '0);

    // An aligned byte store enables exactly one lane (R6).
    assert_byte_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && size_q == 2'd0 |-> $countones(byte_en) == 1);

    // An idle cycle leaves no valid result and keeps the address (R9).
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> !out_valid && !wb_en && $stable(eff_addr));
endmodule

// File: tb/lsu_agu_tb_top.sv
`timescale 1ns/1ps
module lsu_agu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic [11:0] imm_off = '0;
    logic [31:0] reg_off = '0;
    logic [4:0]  shift_amt = '0;
    logic        off_is_reg = 1'b0;
    logic        off_up = 1'b1;
    logic [1:0]  idx_mode = '0;
    logic [1:0]  acc_size = 2'd2;
    logic        ld_signed = 1'b0;
    logic [31:0] st_data = '0;
    logic [31:0] ld_rdata = '0;
    logic        out_valid, wb_en, misalign;
    logic [31:0] eff_addr, wb_value, st_lanes, ld_value;
    logic [3:0]  byte_en;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lsu_agu dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_val(base_val),
        .imm_off(imm_off), .reg_off(reg_off), .shift_amt(shift_amt),
        .off_is_reg(off_is_reg), .off_up(off_up), .idx_mode(idx_mode),
        .acc_size(acc_size), .ld_signed(ld_signed), .st_data(st_data),
        .ld_rdata(ld_rdata), .out_valid(out_valid), .eff_addr(eff_addr),
        .wb_value(wb_value), .wb_en(wb_en), .misalign(misalign),
        .byte_en(byte_en), .st_lanes(st_lanes), .ld_value(ld_value)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements.
    function automatic logic [31:0] f_off(logic [11:0] im, logic [31:0] ro, logic [4:0] sh, logic ur);
        return ur ? (ro << sh) : {20'b0, im};
    endfunction

    function automatic logic f_mis(logic [31:0] a, logic [1:0] sz);
        if (sz == 2'd0) return 1'b0;
        if (sz == 2'd1) return a[0];
        return |a[1:0];
    endfunction

    function automatic logic [3:0] f_be(logic [31:0] a, logic [1:0] sz);
        if (f_mis(a, sz)) return 4'b0000;
        if (sz == 2'd0) return 4'b0001 << a[1:0];
        if (sz == 2'd1) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] f_lanes(logic [31:0] d, logic [1:0] sz);
        if (sz == 2'd0) return {4{d[7:0]}};
        if (sz == 2'd1) return {2{d[15:0]}};
        return d;
    endfunction

    function automatic logic [31:0] f_ld(logic [31:0] rd, logic [31:0] a, logic [1:0] sz, logic sg);
        logic [7:0]  b;
        logic [15:0] h;
        b = 8'(rd >> (8 * a[1:0]));
        h = a[1] ? rd[31:16] : rd[15:0];
        if (sz == 2'd0) return {{24{sg & b[7]}}, b};
        if (sz == 2'd1) return {{16{sg & h[15]}}, h};
        return rd;
    endfunction

    // Drive one request, check registered outputs, then the load path.
    task automatic run_req(input logic [31:0] b, input logic [11:0] im, input logic [31:0] ro,
                           input logic [4:0] sh, input logic ur, input logic up,
                           input logic [1:0] md, input logic [1:0] sz, input logic sg,
                           input logic [31:0] sd, input logic [31:0] rd);
        logic [31:0] off, sum, ea;
        logic        wbe;
        req_valid = 1'b1; base_val = b; imm_off = im; reg_off = ro; shift_amt = sh;
        off_is_reg = ur; off_up = up; idx_mode = md; acc_size = sz; ld_signed = sg;
        st_data = sd;
        @(negedge clk);
        off = f_off(im, ro, sh, ur);
        sum = up ? b + off : b - off;
        ea  = (md == 2'd2) ? b : sum;
        wbe = (md == 2'd1) || (md == 2'd2);
        chk("R4/R1/R3 eff_addr", eff_addr, ea);
        chk("R1/R2/R10 wb_en", {31'b0, wb_en}, {31'b0, wbe});
        if (wbe) chk("R2/R3 wb_value", wb_value, sum);
        chk("R5 misalign", {31'b0, misalign}, {31'b0, f_mis(ea, sz)});
        chk("R6 byte_en", {28'b0, byte_en}, {28'b0, f_be(ea, sz)});
        chk("R6 st_lanes", st_lanes, f_lanes(sd, sz));
        chk("R9 out_valid", {31'b0, out_valid}, 32'd1);
        ld_rdata = rd;
        #1;
        chk("R7 ld_value", ld_value, f_ld(rd, ea, sz, sg));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] held;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk("R8 out_valid", {31'b0, out_valid}, 32'd0);
        chk("R8 wb_en", {31'b0, wb_en}, 32'd0);
        chk("R8 eff_addr", eff_addr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 preindex with immediate add, word aligned
        run_req(32'h0000_1000, 12'd8, 0, 0, 0, 1, 2'd0, 2'd2, 0, 32'hCAFE_F00D, 32'h1122_3344);
        // R4 subtract register offset
        run_req(32'h0000_1000, 12'd0, 32'd8, 0, 1, 0, 2'd0, 2'd2, 0, 0, 0);
        // R2 scaled register with writeback
        run_req(32'h0008_0010, 12'd0, 32'd3, 5'd2, 1, 1, 2'd1, 2'd2, 0, 0, 0);
        // R3 postindex subtract immediate
        run_req(32'h0000_2000, 12'd4, 0, 0, 0, 0, 2'd2, 2'd2, 0, 0, 0);
        // R4 maximum shift of 31
        run_req(32'h0000_0010, 12'd0, 32'd1, 5'd31, 1, 1, 2'd0, 2'd2, 0, 0, 0);
        // R4 wrap past the top of the address space
        run_req(32'hFFFF_FFFC, 12'd8, 0, 0, 0, 1, 2'd1, 2'd2, 0, 0, 0);
        // R10 spare mode code acts as preindex
        run_req(32'h0000_3000, 12'hFFF, 0, 0, 0, 1, 2'd3, 2'd0, 0, 0, 0);
        // R5 misaligned word and halfword, R6 enables cleared
        run_req(32'h0000_1002, 12'd0, 0, 0, 0, 1, 2'd0, 2'd2, 0, 32'h1234_5678, 0);
        run_req(32'h0000_1001, 12'd0, 0, 0, 0, 1, 2'd0, 2'd1, 0, 32'h1234_5678, 0);
        // R6 byte store at lane 3 and R7 signed byte load
        run_req(32'h0000_1003, 12'd0, 0, 0, 0, 1, 2'd0, 2'd0, 1, 32'h0000_00AB, 32'h80FF_7F01);
        // R7 signed halfword in upper lane, size code 3 as word
        run_req(32'h0000_1002, 12'd0, 0, 0, 0, 1, 2'd0, 2'd1, 1, 32'h0000_BEEF, 32'h9ABC_0000);
        run_req(32'h0000_1004, 12'd0, 0, 0, 0, 1, 2'd0, 2'd3, 1, 32'h8765_4321, 32'h8000_0001);

        // R9 idle cycle: outputs drop valid and hold the address
        held = eff_addr;
        req_valid = 1'b0;
        base_val = 32'hDEAD_0000;
        idx_mode = 2'd1;
        @(negedge clk);
        chk("R9 idle out_valid", {31'b0, out_valid}, 32'd0);
        chk("R9 idle wb_en", {31'b0, wb_en}, 32'd0);
        chk("R9 idle eff_addr", eff_addr, held);

        // Random mix over every field
        for (int i = 0; i < 400; i++) begin
            run_req($urandom(), 12'($urandom()), $urandom(), 5'($urandom()), 1'($urandom()),
                    1'($urandom()), 2'($urandom()), 2'($urandom()), 1'($urandom()),
                    $urandom(), $urandom());
        end
        req_valid = 1'b0;
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule